// File: doc/BRIEF.md
# Deficit Round Position Calculator

This unit decides which round FIFO an arriving packet must join in a scheduler that keeps one FIFO per service round instead of one queue per flow. The chosen round is the one in which a deficit round-robin scheduler would have sent the packet. The caller reads a flow's state and supplies it together with the packet size, the flow weight and the maximum packet size. The unit returns the round index and the deficit value the caller should write back.

A request is a one-cycle `start` pulse. All request inputs are captured on that edge. The unit first applies the once-per-round deficit top-up when it is due. It then forms the backlog ahead of the packet and divides it by the flow quantum, rounding up, with a restoring divider. Finally it adds the current round and reduces the sum modulo the number of rounds.

Every request takes the same number of cycles. The results stay on the outputs until the next result replaces them. A quotient that would reach past the last round is flagged and does not wrap silently.

Top module: `rndpos_calc`

## Requirements
- R1: With quantum q = weight × mtu, numerator n = backlog − deficit' + pkt_size (deficit' is the adjusted deficit), and k = ceil(n / q) − 1 < NUM_ROUNDS (default 12), `pos` equals (cur_round + k) mod NUM_ROUNDS. An exact multiple of q is not rounded up further.
- R2: When `new_flow` is 0, `flow_round` differs from `cur_round` and `deficit` is negative, the deficit is raised by q before the position is computed. `def_out` carries the raised value.
- R3: When `flow_round` equals `cur_round`, or `deficit` is zero or positive, the deficit is used unchanged and `def_out` equals `deficit`.
- R4: When `new_flow` is 1, backlog and deficit are taken as zero and `def_out` is 0, whatever values sit on those inputs. A packet no larger than q then lands in `cur_round`.
- R5: A numerator n of zero or below places the packet in `cur_round`.
- R6: When cur_round + k reaches NUM_ROUNDS or more, the index wraps, so `pos` = cur_round + k − NUM_ROUNDS.
- R7: When k ≥ NUM_ROUNDS, `err` is 1 and `pos` is the round just before `cur_round` (NUM_ROUNDS − 1 when `cur_round` is 0). Otherwise `err` is 0.
- R8: `done` is a one-cycle pulse. It goes high after the 20th rising edge that follows the edge accepting `start` (NUM_W + 2 edges, NUM_W = 18 by default).
- R9: A `start` that arrives while a request is in progress is ignored. Between `done` pulses, `pos`, `def_out` and `err` hold their values.
- R10: While `rst` is high, and after it until the first result, `done`, `pos`, `def_out` and `err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when idle |
| cur_round | input | RIDX_W (4) | Round index now being served |
| flow_round | input | RIDX_W (4) | Round in which the flow last sent |
| new_flow | input | 1 | Flow has no stored state yet |
| backlog | input | BYTES_W (16) | Bytes the flow already has queued |
| deficit | input | WGT_W+MTU_W+1 (16) | Signed stored deficit of the flow |
| pkt_size | input | SIZE_W (11) | Size of the arriving packet in bytes |
| weight | input | WGT_W (4) | Flow weight, at least 1 |
| mtu | input | MTU_W (11) | Maximum packet size in bytes |
| done | output | 1 | Result valid pulse |
| pos | output | RIDX_W (4) | Round FIFO index to join |
| def_out | output | WGT_W+MTU_W+1 (16) | Signed deficit after the top-up |
| err | output | 1 | Quotient exceeds the round range |

## Verification
The bench goes after the ceiling boundary by using a numerator that is an exact multiple of the quantum and one that is a single byte above it. A design that always rounds up, or always truncates, puts one of the two packets one round off. It checks each half of the top-up condition alone and a new flow sitting on stale backlog and deficit values; a wrong condition shows up as a wrong `def_out` and a shifted `pos`. It drives a wrap past the last round, the largest in-range quotient next to the first out-of-range one, and a numerator below zero, which a design without clamping would turn into a huge quotient. It also issues a second request mid-computation, which a design that restarts or overwrites its captured inputs would answer with the wrong result or at the wrong time.

// File: rtl/rndpos_pkg.sv
package rndpos_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_DIV  = 2'd2
  } rndpos_state_t;

  function automatic int unsigned wider(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rndpos_adjust.sv
module rndpos_adjust #(
  parameter int BYTES_W = 16,
  parameter int SIZE_W  = 11,
  parameter int WGT_W   = 4,
  parameter int MTU_W   = 11,
  parameter int RIDX_W  = 4,
  parameter int NUM_W   = 18,
  localparam int QW     = WGT_W + MTU_W,
  localparam int DEF_W  = QW + 1
) (
  input  logic                    new_flow,
  input  logic [RIDX_W-1:0]       cur_round,
  input  logic [RIDX_W-1:0]       flow_round,
  input  logic [BYTES_W-1:0]      backlog,
  input  logic signed [DEF_W-1:0] deficit,
  input  logic [SIZE_W-1:0]       pkt_size,
  input  logic [WGT_W-1:0]        weight,
  input  logic [MTU_W-1:0]        mtu,
  output logic signed [DEF_W-1:0] def_adj,
  output logic [QW-1:0]           quantum,
  output logic [NUM_W-1:0]        dividend
);

  localparam int SW = NUM_W + 1;

  logic            topup;
  logic [SW-1:0]   b_ext;
  logic [SW-1:0]   d_ext;
  logic [SW-1:0]   s_ext;
  logic [SW-1:0]   numer;
  logic [NUM_W-1:0] numer_pos;

  always_comb begin
    quantum = {{MTU_W{1'b0}}, weight} * {{WGT_W{1'b0}}, mtu};
    topup   = !new_flow && (flow_round != cur_round) && deficit[DEF_W-1];
    if (new_flow)
      def_adj = '0;
    else if (topup)
      def_adj = deficit + $signed({1'b0, quantum});
    else
      def_adj = deficit;

    b_ext = new_flow ? '0 : {{(SW-BYTES_W){1'b0}}, backlog};
    d_ext = {{(SW-DEF_W){def_adj[DEF_W-1]}}, def_adj};
    s_ext = {{(SW-SIZE_W){1'b0}}, pkt_size};
    numer = b_ext - d_ext + s_ext;

    if (numer[SW-1] || (numer == '0))
      numer_pos = NUM_W'(1);
    else
      numer_pos = numer[NUM_W-1:0];

    dividend = numer_pos + NUM_W'(quantum) - NUM_W'(1);
  end

endmodule

// File: rtl/rndpos_divider.sv
module rndpos_divider #(
  parameter int NUM_W = 18,
  parameter int DVS_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [NUM_W-1:0] quotient,
  output logic             ready
);

  localparam int CW = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] dvd;
  logic [DVS_W:0]   rem;
  logic [DVS_W:0]   rem_sh;
  logic [DVS_W:0]   rem_nx;
  logic             fits;
  logic [CW-1:0]    cnt;

  always_comb begin
    rem_sh = {rem[DVS_W-1:0], dvd[NUM_W-1]};
    fits   = (rem_sh >= {1'b0, divisor});
    rem_nx = fits ? (rem_sh - {1'b0, divisor}) : rem_sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd <= '0;
      rem <= '0;
      cnt <= '0;
    end else if (load) begin
      dvd <= dividend;
      rem <= '0;
      cnt <= CW'(NUM_W);
    end else if (cnt != '0) begin
      rem <= rem_nx;
      dvd <= {dvd[NUM_W-2:0], fits};
      cnt <= cnt - CW'(1);
    end
  end

  assign quotient = dvd;
  assign ready    = (cnt == '0);

endmodule

// File: rtl/rndpos_wrap.sv
module rndpos_wrap #(
  parameter int NUM_W      = 18,
  parameter int NUM_ROUNDS = 12,
  parameter int RIDX_W     = 4
) (
  input  logic [NUM_W-1:0]  quot,
  input  logic [RIDX_W-1:0] cur_round,
  output logic [RIDX_W-1:0] pos,
  output logic              err
);

  logic [NUM_W-1:0]  ahead;
  logic [RIDX_W:0]   sum;
  logic [RIDX_W-1:0] prev_round;

  always_comb begin
    ahead = quot - NUM_W'(1);
    err   = (ahead >= NUM_W'(NUM_ROUNDS));
    sum   = {1'b0, cur_round} + {1'b0, ahead[RIDX_W-1:0]};
    if (sum >= (RIDX_W+1)'(NUM_ROUNDS))
      sum = sum - (RIDX_W+1)'(NUM_ROUNDS);
    prev_round = (cur_round == '0) ? RIDX_W'(NUM_ROUNDS - 1) : (cur_round - RIDX_W'(1));
    pos = err ? prev_round : sum[RIDX_W-1:0];
  end

endmodule

// File: rtl/rndpos_calc.sv
module rndpos_calc
  import rndpos_pkg::*;
#(
  parameter int BYTES_W    = 16,
  parameter int SIZE_W     = 11,
  parameter int WGT_W      = 4,
  parameter int MTU_W      = 11,
  parameter int NUM_ROUNDS = 12,
  localparam int RIDX_W    = $clog2(NUM_ROUNDS),
  localparam int QW        = WGT_W + MTU_W,
  localparam int DEF_W     = QW + 1,
  localparam int NUM_W     = wider(BYTES_W, QW) + 2,
  localparam int LATENCY   = NUM_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [RIDX_W-1:0]       cur_round,
  input  logic [RIDX_W-1:0]       flow_round,
  input  logic                    new_flow,
  input  logic [BYTES_W-1:0]      backlog,
  input  logic signed [DEF_W-1:0] deficit,
  input  logic [SIZE_W-1:0]       pkt_size,
  input  logic [WGT_W-1:0]        weight,
  input  logic [MTU_W-1:0]        mtu,
  output logic                    done,
  output logic [RIDX_W-1:0]       pos,
  output logic signed [DEF_W-1:0] def_out,
  output logic                    err
);

  rndpos_state_t state;

  logic [RIDX_W-1:0]       r_cur;
  logic [RIDX_W-1:0]       r_flow;
  logic                    r_new;
  logic [BYTES_W-1:0]      r_backlog;
  logic signed [DEF_W-1:0] r_def;
  logic [SIZE_W-1:0]       r_size;
  logic [WGT_W-1:0]        r_weight;
  logic [MTU_W-1:0]        r_mtu;
  logic signed [DEF_W-1:0] def_hold;

  logic signed [DEF_W-1:0] def_adj;
  logic [QW-1:0]           quantum;
  logic [NUM_W-1:0]        dividend;
  logic [NUM_W-1:0]        quotient;
  logic                    div_ready;
  logic [RIDX_W-1:0]       w_pos;
  logic                    w_err;

  rndpos_adjust #(
    .BYTES_W(BYTES_W), .SIZE_W(SIZE_W), .WGT_W(WGT_W),
    .MTU_W(MTU_W), .RIDX_W(RIDX_W), .NUM_W(NUM_W)
  ) u_adjust (
    .new_flow  (r_new),
    .cur_round (r_cur),
    .flow_round(r_flow),
    .backlog   (r_backlog),
    .deficit   (r_def),
    .pkt_size  (r_size),
    .weight    (r_weight),
    .mtu       (r_mtu),
    .def_adj   (def_adj),
    .quantum   (quantum),
    .dividend  (dividend)
  );

  rndpos_divider #(.NUM_W(NUM_W), .DVS_W(QW)) u_div (
    .clk     (clk),
    .rst     (rst),
    .load    (state == ST_PREP),
    .dividend(dividend),
    .divisor (quantum),
    .quotient(quotient),
    .ready   (div_ready)
  );

  rndpos_wrap #(.NUM_W(NUM_W), .NUM_ROUNDS(NUM_ROUNDS), .RIDX_W(RIDX_W)) u_wrap (
    .quot     (quotient),
    .cur_round(r_cur),
    .pos      (w_pos),
    .err      (w_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      r_cur     <= '0;
      r_flow    <= '0;
      r_new     <= 1'b0;
      r_backlog <= '0;
      r_def     <= '0;
      r_size    <= '0;
      r_weight  <= '0;
      r_mtu     <= '0;
      def_hold  <= '0;
      done      <= 1'b0;
      pos       <= '0;
      def_out   <= '0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            r_cur     <= cur_round;
            r_flow    <= flow_round;
            r_new     <= new_flow;
            r_backlog <= backlog;
            r_def     <= deficit;
            r_size    <= pkt_size;
            r_weight  <= weight;
            r_mtu     <= mtu;
            state     <= ST_PREP;
          end
        end
        ST_PREP: begin
          def_hold <= def_adj;
          state    <= ST_DIV;
        end
        ST_DIV: begin
          if (div_ready) begin
            pos     <= w_pos;
            err     <= w_err;
            def_out <= def_hold;
            done    <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rndpos_chk.sv
module rndpos_chk #(
  parameter int NUM_ROUNDS = 12,
  parameter int RIDX_W     = 4,
  parameter int DEF_W      = 16,
  parameter int LAT        = 20
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    new_flow,
  input logic [RIDX_W-1:0]       cur_round,
  input logic                    done,
  input logic [RIDX_W-1:0]       pos,
  input logic signed [DEF_W-1:0] def_out,
  input logic                    err
);

  localparam int CW = $clog2(LAT + 1) + 1;

  logic              c_busy;
  logic [CW-1:0]     c_cnt;
  logic              c_nf;
  logic [RIDX_W-1:0] c_cur;
  logic              c_take;

  assign c_take = start && (!c_busy || (c_cnt == CW'(LAT)));

  always_ff @(posedge clk) begin
    if (rst) begin
      c_busy <= 1'b0;
      c_cnt  <= '0;
      c_nf   <= 1'b0;
      c_cur  <= '0;
    end else if (c_take) begin
      c_busy <= 1'b1;
      c_cnt  <= '0;
      c_nf   <= new_flow;
      c_cur  <= cur_round;
    end else if (c_busy) begin
      if (c_cnt == CW'(LAT))
        c_busy <= 1'b0;
      else
        c_cnt <= c_cnt + CW'(1);
    end
  end

  AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (rst)
    done |-> (c_busy && (c_cnt == CW'(LAT)))); // R8

  AST_DONE_DUE: assert property (@(posedge clk) disable iff (rst)
    (c_busy && (c_cnt == CW'(LAT))) |-> done); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(pos) && $stable(def_out) && $stable(err))); // R9

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    done |-> (pos < RIDX_W'(NUM_ROUNDS))); // R1

  AST_NEW_FLOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && c_nf) |-> (def_out == '0)); // R4

  AST_ERR_POS: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (pos == ((c_cur == '0) ? RIDX_W'(NUM_ROUNDS - 1) : (c_cur - RIDX_W'(1))))); // R7

endmodule

bind rndpos_calc rndpos_chk #(
  .NUM_ROUNDS(NUM_ROUNDS), .RIDX_W(RIDX_W), .DEF_W(DEF_W), .LAT(LATENCY)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .new_flow(new_flow),
  .cur_round(cur_round), .done(done), .pos(pos), .def_out(def_out), .err(err)
);

// File: tb/tb_rndpos_calc.sv
`timescale 1ns/1ps
module tb_rndpos_calc;

  localparam int M   = 12;
  localparam int LAT = 20;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start = 1'b0;
  logic [3:0]         cur_round = '0;
  logic [3:0]         flow_round = '0;
  logic               new_flow = 1'b0;
  logic [15:0]        backlog = '0;
  logic signed [15:0] deficit = '0;
  logic [10:0]        pkt_size = '0;
  logic [3:0]         weight = 4'd1;
  logic [10:0]        mtu = 11'd1000;
  logic               done;
  logic [3:0]         pos;
  logic signed [15:0] def_out;
  logic               err;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R10";
  bit    finished = 1'b0;

  // reference model state
  bit mbusy;
  int mcnt;
  int e_done, e_pos, e_def, e_err;
  int p_pos, p_def, p_err;

  rndpos_calc dut (
    .clk(clk), .rst(rst), .start(start), .cur_round(cur_round),
    .flow_round(flow_round), .new_flow(new_flow), .backlog(backlog),
    .deficit(deficit), .pkt_size(pkt_size), .weight(weight), .mtu(mtu),
    .done(done), .pos(pos), .def_out(def_out), .err(err)
  );

  always #10 clk = ~clk;

  task automatic ref_calc();
    int q, d, b, n, qq, k;
    q = int'(weight) * int'(mtu);
    d = new_flow ? 0 : int'(deficit);
    b = new_flow ? 0 : int'(backlog);
    if (!new_flow && (flow_round != cur_round) && (d < 0)) d = d + q;
    n = b - d + int'(pkt_size);
    if (n < 1) n = 1;
    qq = (n + q - 1) / q;
    k = qq - 1;
    p_def = d;
    if (k >= M) begin
      p_err = 1;
      p_pos = (int'(cur_round) + M - 1) % M;
    end else begin
      p_err = 0;
      p_pos = (int'(cur_round) + k) % M;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mbusy = 1'b0; mcnt = 0;
      e_done = 0; e_pos = 0; e_def = 0; e_err = 0;
    end else if (mbusy) begin
      mcnt = mcnt - 1;
      if (mcnt == 0) begin
        e_done = 1; e_pos = p_pos; e_def = p_def; e_err = p_err;
        mbusy = 1'b0;
      end else begin
        e_done = 0;
      end
    end else begin
      e_done = 0;
      if (start) begin
        ref_calc();
        mbusy = 1'b1;
        mcnt = LAT;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model (R8 timing, R9 holding)
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(cur_req, "done", int'(done), e_done);
      check(cur_req, "pos", int'(pos), e_pos);
      check(cur_req, "def_out", int'(def_out), e_def);
      check(cur_req, "err", int'(err), e_err);
    end
  end

  task automatic issue(input string req, input int cur, input int fr, input int nf,
                       input int bl, input int df, input int sz, input int w, input int mt);
    @(negedge clk);
    cur_req    = req;
    cur_round  = 4'(cur);
    flow_round = 4'(fr);
    new_flow   = nf[0];
    backlog    = 16'(bl);
    deficit    = 16'(df);
    pkt_size   = 11'(sz);
    weight     = 4'(w);
    mtu        = 11'(mt);
    start      = 1'b1;
    @(negedge clk);
    start      = 1'b0;
  endtask

  task automatic settle();
    repeat (LAT + 3) @(negedge clk);
  endtask

  task automatic direct(input string req, input int exp_pos, input int exp_def, input int exp_err);
    check(req, "pos direct", int'(pos), exp_pos);
    check(req, "def_out direct", int'(def_out), exp_def);
    check(req, "err direct", int'(err), exp_err);
  endtask

  initial begin
    // R10: reset values
    repeat (3) @(negedge clk);
    check("R10", "done in reset", int'(done), 0);
    check("R10", "pos in reset", int'(pos), 0);
    check("R10", "def_out in reset", int'(def_out), 0);
    check("R10", "err in reset", int'(err), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1: exact multiple of the quantum, n=3000, q=1000 -> k=2
    issue("R1", 3, 3, 0, 2500, 200, 700, 1, 1000); settle();
    direct("R1", 5, 200, 0);
    // R1: one byte above the multiple, n=3001 -> k=3
    issue("R1", 3, 3, 0, 2501, 200, 700, 1, 1000); settle();
    direct("R1", 6, 200, 0);
    // R2: new round, negative deficit topped up: -300+2000=1700, n=2100, q=2000
    issue("R2", 5, 4, 0, 3000, -300, 800, 2, 1000); settle();
    direct("R2", 6, 1700, 0);
    // R2: widest values, deficit at -q lifted to 0
    issue("R2", 0, 11, 0, 65535, -30705, 2047, 15, 2047); settle();
    direct("R2", 2, 0, 0);
    // R3: same round keeps negative deficit: n=4100, q=2000 -> k=2
    issue("R3", 5, 5, 0, 3000, -300, 800, 2, 1000); settle();
    direct("R3", 7, -300, 0);
    // R3: different round, positive deficit kept: n=2500 -> k=2
    issue("R3", 1, 6, 0, 2000, 400, 900, 1, 1000); settle();
    direct("R3", 3, 400, 0);
    // R4: new flow ignores stale backlog/deficit, 1500 <= q=2000
    issue("R4", 7, 2, 1, 9999, -50, 1500, 2, 1000); settle();
    direct("R4", 7, 0, 0);
    // R5: negative numerator (0 - 900 + 100)
    issue("R5", 9, 9, 0, 0, 900, 100, 1, 1000); settle();
    direct("R5", 9, 900, 0);
    // R6: wrap 10 + 4 = 14 -> 2
    issue("R6", 10, 10, 0, 4000, 0, 1000, 1, 1000); settle();
    direct("R6", 2, 0, 0);
    // R7: largest in-range k=11 from cur 4 -> 3, no error
    issue("R7", 4, 4, 0, 11000, 0, 1000, 1, 1000); settle();
    direct("R7", 3, 0, 0);
    // R7: first out-of-range k=12 -> error, previous round 3
    issue("R7", 4, 4, 0, 12000, 0, 1000, 1, 1000); settle();
    direct("R7", 3, 0, 1);
    // R7: out of range at cur 0 -> round 11
    issue("R7", 0, 0, 0, 20000, 0, 500, 1, 1000); settle();
    direct("R7", 11, 0, 1);
    // R8 and R9: second start mid-computation is ignored
    issue("R9", 2, 2, 0, 1500, 0, 400, 1, 1000);
    repeat (5) @(negedge clk);
    issue("R9", 8, 3, 0, 9000, -700, 1000, 1, 1000);
    settle();
    direct("R9", 3, 0, 0);
    // R8: back-to-back request right after a done pulse
    issue("R8", 6, 6, 0, 0, 0, 600, 1, 1000);
    @(posedge done);
    @(negedge clk);
    cur_req = "R8"; cur_round = 4'd1; flow_round = 4'd1; new_flow = 1'b0;
    backlog = 16'd1200; deficit = '0; pkt_size = 11'd300; weight = 4'd1; mtu = 11'd1000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    settle();
    direct("R8", 2, 0, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog %s actual=timeout expected=completion", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule